// File: doc/BRIEF.md
# Paged Receive Ring Writer

The block stores frames that have already passed address filtering into a circular receive area of local packet RAM. The area is cut into 256-byte pages. Four 8-bit page registers describe it: the first page of the ring (`pg_start`), the page one past its end (`pg_stop`), the page the writer fills next (`cur_page`), and the oldest page the host has not yet freed (`pg_bound`). Each frame is announced by a start pulse that carries its byte count. The bytes then follow on a valid/ready stream.

Before any byte is written, the writer works out how many whole pages the frame needs, counting the 4-byte header and 4 bytes of CRC. It compares that with the pages still free. A frame that does not fit is read in and thrown away, so the ring never holds half a frame. A frame that fits is written starting at byte 4 of the current page, and any bytes past the last ring page continue on the first ring page. Frames shorter than 60 bytes are padded with zero bytes. The 4-byte header is written last, into bytes 0 to 3 of the starting page. The current page then moves to the page after the frame, a receive flag is raised, and an interrupt is requested if it is enabled.

The controller is a state machine with these states:
- `S_IDLE` waits for a frame.
- `S_CHECK` makes the space decision.
- `S_DATA` writes stream bytes.
- `S_PAD` writes zero fill.
- `S_HDR` writes the four header bytes.
- `S_FINISH` commits the page pointer and flags.
- `S_DROP` swallows a rejected frame.

Its transitions are:
- IDLE→CHECK on a start pulse.
- CHECK→DROP when the writer is halted, `pg_start` is zero or space is short.
- CHECK→DATA when the frame has bytes.
- CHECK→PAD when the length is zero.
- DATA→PAD or DATA→HDR on the last byte, depending on whether padding is needed.
- PAD→HDR on the last fill byte.
- HDR→FINISH after header byte 3.
- FINISH→IDLE.
- DROP→IDLE once every byte is consumed.

Top module: `rx_ring_writer`

## Requirements
- R1: While `halt` is 1, or while `pg_start` is 0, when the frame is checked, the frame is consumed but not stored. No RAM write occurs, `cur_page` and both flags are unchanged.
- R2: The stored length is L = max(len, 60). The number of pages needed is (L + 8 + 255) / 256, using integer division.
- R3: Free pages are `pg_bound - cur_page` when `cur_page < pg_bound`, and otherwise (`pg_stop - pg_start`) - (`cur_page - pg_bound`). When free is less than needed, the frame is dropped with no RAM write, `cur_page` is unchanged and `flag_ovf` is set. When free equals needed, the frame is stored.
- R4: The next page is `cur_page` + needed, reduced by (`pg_stop - pg_start`) when that sum is at or above `pg_stop`. After a stored frame, `cur_page` equals the next page.
- R5: The header occupies addresses {cur,0x00} to {cur,0x03}, in this order:
  - byte 0 is status: bit 0 = 1 (stored OK), bit 5 = bit 0 of the first frame byte (0 for an empty frame), other bits 0;
  - byte 1 is the next page;
  - byte 2 is the low byte of L+4;
  - byte 3 is the high byte of L+4.
- R6: Frame byte k goes to the address reached by stepping k times from {cur,0x04}. A step from offset 0xFF of page `pg_stop - 1` lands on {`pg_start`,0x00}.
- R7: For len < 60, bytes len to 59 of the stored frame are written as 0x00.
- R8: After a stored frame, `flag_rx` and `st_rx_ok` are 1, and `st_group` equals header status bit 5.
- R9: `irq` is 1 exactly when `flag_rx` is 1 and `rx_ie` is 1. Setting bit 0 of `flag_clr` clears `flag_rx`, and setting bit 1 clears `flag_ovf`.
- R10: `cur_load` with `frm_accept` high loads `cur_load_val` into `cur_page` on that edge.
- R11: `in_ready` is 1 only while frame bytes are being consumed, whether the frame is stored or dropped. After exactly len bytes the writer returns to accepting frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Writer stopped; frames are discarded |
| pg_start | input | 8 | First page of the ring |
| pg_stop | input | 8 | Page just past the ring |
| pg_bound | input | 8 | Oldest page still owned by the host |
| cur_load | input | 1 | Load strobe for the current page |
| cur_load_val | input | 8 | Value for the current page |
| cur_page | output | 8 | Current page register |
| rx_ie | input | 1 | Receive interrupt enable |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 clears the receive flag, bit 1 clears the overflow flag |
| frm_accept | output | 1 | Writer is idle and takes a start pulse |
| frm_start | input | 1 | Start of a new frame |
| frm_len | input | 16 | Byte count of the frame, sampled with `frm_start` |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Stream byte taken on this edge if valid |
| mem_we | output | 1 | Packet RAM write enable |
| mem_addr | output | 16 | Packet RAM byte address {page, offset} |
| mem_wdata | output | 8 | Packet RAM write data |
| st_rx_ok | output | 1 | Last frame stored correctly |
| st_group | output | 1 | Last stored frame had a group destination |
| flag_rx | output | 1 | Frame-received flag |
| flag_ovf | output | 1 | Frame-dropped-for-space flag |
| irq | output | 1 | Interrupt request |

## Verification
The checker holds every cycle to the following rules:
- No RAM write happens in the drop state.
- Header writes stay on the current page.
- Every write address lies inside the ring.
- The stream is only accepted while bytes are being consumed.
- The current page moves only on a commit or a host load.
- A masked receive interrupt never reaches `irq`.

The space arithmetic, the wrap of data across `pg_stop`, the header contents, zero padding and the exact-fit boundary can only be shown by the bench's scenarios. The bench compares the captured RAM writes and the ring registers after each frame against its own page model.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int RXR_HDR_BYTES = 4;
    localparam int RXR_CRC_BYTES = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_DATA,
        S_PAD,
        S_HDR,
        S_FINISH,
        S_DROP
    } rxr_state_e;
endpackage

// File: rtl/rxr_space.sv
// Page arithmetic: pages needed, free pages, fit decision and next page.
module rxr_space import rxr_pkg::*; #(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 8,
    parameter int LEN_W  = 16
) (
    input  logic [LEN_W-1:0]  len_eff,
    input  logic [PAGE_W-1:0] cur,
    input  logic [PAGE_W-1:0] bnd,
    input  logic [PAGE_W-1:0] start,
    input  logic [PAGE_W-1:0] stop,
    output logic              fits,
    output logic [PAGE_W-1:0] next_page
);
    localparam int SUM_W  = LEN_W + 2;
    localparam int NEED_W = SUM_W - OFS_W;
    localparam int CW     = (NEED_W > PAGE_W + 1) ? NEED_W : PAGE_W + 2;
    localparam int ROUND  = RXR_HDR_BYTES + RXR_CRC_BYTES + (1 << OFS_W) - 1;

    logic [SUM_W-1:0] total;
    logic [CW-1:0]    need, ring, free_pg, sum;

    always_comb begin
        total = SUM_W'(len_eff) + SUM_W'(ROUND);
        need  = CW'(total[SUM_W-1:OFS_W]);
        ring  = CW'(stop) - CW'(start);
        if (cur < bnd)
            free_pg = CW'(bnd) - CW'(cur);
        else
            free_pg = ring - (CW'(cur) - CW'(bnd));
        fits = (free_pg >= need);
        sum  = CW'(cur) + need;
        if (sum >= CW'(stop))
            sum = sum - ring;
        next_page = PAGE_W'(sum);
    end
endmodule

// File: rtl/rxr_step.sv
// Advances a byte address by one, wrapping from the end of the ring to its start.
module rxr_step #(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 8
) (
    input  logic [PAGE_W+OFS_W-1:0] addr,
    input  logic [PAGE_W-1:0]       start,
    input  logic [PAGE_W-1:0]       stop,
    output logic [PAGE_W+OFS_W-1:0] addr_nx
);
    logic [PAGE_W:0] pg_inc;

    always_comb begin
        pg_inc  = {1'b0, addr[PAGE_W+OFS_W-1:OFS_W]} + 1'b1;
        addr_nx = addr + 1'b1;
        if ((addr[OFS_W-1:0] == {OFS_W{1'b1}}) && (pg_inc == {1'b0, stop}))
            addr_nx = {start, {OFS_W{1'b0}}};
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer import rxr_pkg::*; #(
    parameter int PAGE_W  = 8,
    parameter int OFS_W   = 8,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic [PAGE_W-1:0] pg_start,
    input  logic [PAGE_W-1:0] pg_stop,
    input  logic [PAGE_W-1:0] pg_bound,
    input  logic              cur_load,
    input  logic [PAGE_W-1:0] cur_load_val,
    output logic [PAGE_W-1:0] cur_page,
    input  logic              rx_ie,
    input  logic [1:0]        flag_clr,
    output logic              frm_accept,
    input  logic              frm_start,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              mem_we,
    output logic [PAGE_W+OFS_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              st_rx_ok,
    output logic              st_group,
    output logic              flag_rx,
    output logic              flag_ovf,
    output logic              irq
);
    localparam int ADDR_W = PAGE_W + OFS_W;

    rxr_state_e         st_q, st_d;
    logic [LEN_W-1:0]   len_q, rem_q, pad_q, len_eff, len_hdr;
    logic [ADDR_W-1:0]  ptr_q, ptr_nx;
    logic [PAGE_W-1:0]  next_q, next_c;
    logic [1:0]         hidx_q;
    logic               group_q, fits;
    logic               blocked, short_frm, take;

    assign len_eff   = (len_q < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : len_q;
    assign len_hdr   = len_eff + LEN_W'(RXR_HDR_BYTES);
    assign short_frm = (len_q < LEN_W'(MIN_LEN));
    assign blocked   = halt || (pg_start == '0);
    assign take      = in_ready && in_valid;

    rxr_space #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .LEN_W(LEN_W)) space_i (
        .len_eff(len_eff), .cur(cur_page), .bnd(pg_bound),
        .start(pg_start), .stop(pg_stop), .fits(fits), .next_page(next_c)
    );

    rxr_step #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) step_i (
        .addr(ptr_q), .start(pg_start), .stop(pg_stop), .addr_nx(ptr_nx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (frm_start) st_d = S_CHECK;
            S_CHECK: begin
                if (blocked || !fits)  st_d = S_DROP;
                else if (len_q == '0)  st_d = S_PAD;
                else                   st_d = S_DATA;
            end
            S_DATA:   if (take && rem_q == LEN_W'(1))
                          st_d = short_frm ? S_PAD : S_HDR;
            S_PAD:    if (pad_q == LEN_W'(1)) st_d = S_HDR;
            S_HDR:    if (hidx_q == 2'd3) st_d = S_FINISH;
            S_FINISH: st_d = S_IDLE;
            S_DROP:   if (rem_q == '0 || (take && rem_q == LEN_W'(1))) st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        frm_accept = (st_q == S_IDLE);
        in_ready   = ((st_q == S_DATA) || (st_q == S_DROP)) && (rem_q != '0);
        mem_we     = 1'b0;
        mem_addr   = ptr_q;
        mem_wdata  = 8'h00;
        unique case (st_q)
            S_DATA: begin
                mem_we    = in_valid;
                mem_wdata = in_data;
            end
            S_PAD: mem_we = 1'b1;
            S_HDR: begin
                mem_we   = 1'b1;
                mem_addr = {cur_page, {(OFS_W-2){1'b0}}, hidx_q};
                unique case (hidx_q)
                    2'd0:    mem_wdata = {2'b00, group_q, 4'b0000, 1'b1};
                    2'd1:    mem_wdata = next_q;
                    2'd2:    mem_wdata = len_hdr[7:0];
                    default: mem_wdata = len_hdr[15:8];
                endcase
            end
            default: ;
        endcase
        irq = flag_rx && rx_ie;
    end

    // Datapath and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            rem_q    <= '0;
            pad_q    <= '0;
            ptr_q    <= '0;
            next_q   <= '0;
            hidx_q   <= '0;
            group_q  <= 1'b0;
            cur_page <= '0;
            flag_rx  <= 1'b0;
            flag_ovf <= 1'b0;
            st_rx_ok <= 1'b0;
            st_group <= 1'b0;
        end else begin
            if (flag_clr[0]) flag_rx  <= 1'b0;
            if (flag_clr[1]) flag_ovf <= 1'b0;
            unique case (st_q)
                S_IDLE: begin
                    if (cur_load) cur_page <= cur_load_val;
                    if (frm_start) begin
                        len_q <= frm_len;
                        rem_q <= frm_len;
                    end
                end
                S_CHECK: begin
                    ptr_q   <= {cur_page, OFS_W'(RXR_HDR_BYTES)};
                    next_q  <= next_c;
                    pad_q   <= LEN_W'(MIN_LEN) - len_q;
                    hidx_q  <= '0;
                    group_q <= 1'b0;
                    if (!blocked && !fits) flag_ovf <= 1'b1;
                end
                S_DATA: if (take) begin
                    rem_q <= rem_q - 1'b1;
                    ptr_q <= ptr_nx;
                    if (rem_q == len_q) group_q <= in_data[0];
                end
                S_PAD: begin
                    pad_q <= pad_q - 1'b1;
                    ptr_q <= ptr_nx;
                end
                S_HDR:  hidx_q <= hidx_q + 1'b1;
                S_FINISH: begin
                    cur_page <= next_q;
                    flag_rx  <= 1'b1;
                    st_rx_ok <= 1'b1;
                    st_group <= group_q;
                end
                S_DROP: if (take) rem_q <= rem_q - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker import rxr_pkg::*; #(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input rxr_state_e              st_q,
    input logic [PAGE_W-1:0]       cur_page,
    input logic [PAGE_W-1:0]       pg_start,
    input logic [PAGE_W-1:0]       pg_stop,
    input logic                    cur_load,
    input logic                    mem_we,
    input logic [PAGE_W+OFS_W-1:0] mem_addr,
    input logic                    in_ready,
    input logic                    rx_ie,
    input logic                    irq
);
    // R3: a rejected frame never touches the RAM
    a_r3_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DROP) |-> !mem_we);

    // R5: header bytes land on the current page
    a_r5_hdr_on_cur: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_HDR) |-> (mem_addr[PAGE_W+OFS_W-1:OFS_W] == cur_page));

    // R6: every write stays inside the ring
    a_r6_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[PAGE_W+OFS_W-1:OFS_W] >= pg_start &&
                    mem_addr[PAGE_W+OFS_W-1:OFS_W] <  pg_stop));

    // R4: current page only moves on commit or host load
    a_r4_cur_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_FINISH && !cur_load) |=> $stable(cur_page));

    // R11: stream accepted only while consuming bytes
    a_r11_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (st_q == S_DATA || st_q == S_DROP));

    // R9: masked receive interrupt stays low
    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ie |-> !irq);
endmodule

bind rx_ring_writer rxr_checker #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .st_q(st_q), .cur_page(cur_page),
    .pg_start(pg_start), .pg_stop(pg_stop), .cur_load(cur_load),
    .mem_we(mem_we), .mem_addr(mem_addr), .in_ready(in_ready),
    .rx_ie(rx_ie), .irq(irq)
);

// File: tb/rx_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rx_ring_writer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt = 1'b0;
    logic [7:0] pg_start = 8'h40, pg_stop = 8'h60, pg_bound = 8'h40;
    logic cur_load = 1'b0;
    logic [7:0] cur_load_val = '0;
    logic [7:0] cur_page;
    logic rx_ie = 1'b1;
    logic [1:0] flag_clr = '0;
    logic frm_accept, frm_start = 1'b0;
    logic [15:0] frm_len = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, mem_we;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata;
    logic st_rx_ok, st_group, flag_rx, flag_ovf, irq;

    int nchk = 0, nerr = 0, cycles = 0, wcnt = 0, mcur = 0;
    byte unsigned got[int];

    always #2 clk = ~clk;

    rx_ring_writer dut_i (
        .clk(clk), .rst_n(rst_n), .halt(halt), .pg_start(pg_start), .pg_stop(pg_stop),
        .pg_bound(pg_bound), .cur_load(cur_load), .cur_load_val(cur_load_val),
        .cur_page(cur_page), .rx_ie(rx_ie), .flag_clr(flag_clr), .frm_accept(frm_accept),
        .frm_start(frm_start), .frm_len(frm_len), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .st_rx_ok(st_rx_ok), .st_group(st_group), .flag_rx(flag_rx), .flag_ovf(flag_ovf),
        .irq(irq)
    );

    // capture writes half a cycle after inputs settle
    always @(negedge clk) begin
        #1;
        if (rst_n && mem_we) begin
            got[int'(mem_addr)] = mem_wdata;
            wcnt++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            nerr++;
            $display("FAIL watchdog act=%0d exp<=150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic int pat(input int k, input int tag);
        return (k * 7 + tag * 13 + (k >> 8)) & 255;
    endfunction
    function automatic int f_need(input int len);
        int l = (len < 60) ? 60 : len;
        return (l + 8 + 255) / 256;
    endfunction
    function automatic int f_free(input int cur, input int bnd);
        if (cur < bnd) return bnd - cur;
        return (int'(pg_stop) - int'(pg_start)) - (cur - bnd);
    endfunction
    function automatic int f_next(input int cur, input int need);
        int s = cur + need;
        if (s >= int'(pg_stop)) s -= int'(pg_stop) - int'(pg_start);
        return s;
    endfunction

    task automatic set_cur(input int v);
        @(negedge clk);
        cur_load = 1'b1; cur_load_val = 8'(v);
        @(negedge clk);
        cur_load = 1'b0;
        mcur = v;
        chk("R10", "cur_page after load", cur_page, v);
    endtask

    task automatic clr_flags();
        @(negedge clk); flag_clr = 2'b11;
        @(negedge clk); flag_clr = 2'b00;
    endtask

    // Sends a frame and checks the outcome against the page model.
    task automatic run_frame(input int len, input int tag);
        int i = 0, leff, need, nxt, p, md = 0, mp = 0, stat;
        bit store, space_drop, v, r;
        clr_flags();
        got.delete(); wcnt = 0;
        leff = (len < 60) ? 60 : len;
        need = f_need(len);
        space_drop = !halt && pg_start != 0 && f_free(mcur, int'(pg_bound)) < need;
        store = !halt && pg_start != 0 && !space_drop;
        nxt = f_next(mcur, need);
        while (!frm_accept) @(negedge clk);
        frm_start = 1'b1; frm_len = 16'(len);
        @(negedge clk);
        frm_start = 1'b0;
        while (i < len) begin
            v = ($urandom % 4) != 0;
            in_valid = v; in_data = 8'(pat(i, tag));
            r = in_ready;
            @(negedge clk);
            if (v && r) i++;
        end
        in_valid = 1'b0;
        while (!frm_accept) @(negedge clk);
        @(negedge clk);
        chk("R11", "ready low when idle", in_ready, 0);
        chk(store ? "R2" : (space_drop ? "R3" : "R1"), "write count", wcnt, store ? leff + 4 : 0);
        if (store) begin
            p = mcur * 256 + 4;
            for (int k = 0; k < leff; k++) begin
                if (!got.exists(p) || int'(got[p]) != ((k < len) ? pat(k, tag) : 0)) begin
                    if (k < len) md++; else mp++;
                end
                p++;
                if (p % 256 == 0 && p / 256 == int'(pg_stop)) p = int'(pg_start) * 256;
            end
            chk("R6", "data byte mismatches", md, 0);
            chk("R7", "pad byte mismatches", mp, 0);
            stat = 1 | ((len > 0 && (pat(0, tag) & 1) != 0) ? 32 : 0);
            chk("R5", "hdr status", got.exists(mcur*256) ? int'(got[mcur*256]) : -1, stat);
            chk("R5", "hdr next", got.exists(mcur*256+1) ? int'(got[mcur*256+1]) : -1, nxt);
            chk("R5", "hdr len lo", got.exists(mcur*256+2) ? int'(got[mcur*256+2]) : -1, (leff+4) & 255);
            chk("R5", "hdr len hi", got.exists(mcur*256+3) ? int'(got[mcur*256+3]) : -1, (leff+4) >> 8);
            mcur = nxt;
            chk("R8", "flag_rx", flag_rx, 1);
            chk("R8", "st_rx_ok", st_rx_ok, 1);
            chk("R8", "st_group", st_group, (stat >> 5) & 1);
        end else begin
            chk("R1", "flag_rx after discard", flag_rx, 0);
        end
        chk("R3", "flag_ovf", flag_ovf, space_drop);
        chk("R4", "cur_page", cur_page, mcur);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk("R9", "reset irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "reset cur_page", cur_page, 0);
        chk("R8", "reset flag_rx", flag_rx, 0);
        chk("R3", "reset flag_ovf", flag_ovf, 0);
        chk("R11", "reset ready", in_ready, 0);
        chk("R11", "reset accept", frm_accept, 1);

        set_cur(8'h40); pg_bound = 8'h40;
        run_frame(100, 3);                       // plain store
        chk("R9", "irq enabled", irq, 1);
        @(negedge clk); rx_ie = 1'b0;
        @(negedge clk); chk("R9", "irq masked", irq, 0);
        rx_ie = 1'b1;
        @(negedge clk); flag_clr = 2'b01;
        @(negedge clk); flag_clr = 2'b00;
        chk("R9", "flag_rx cleared", flag_rx, 0);
        chk("R9", "irq after clear", irq, 0);

        run_frame(20, 4);                        // short frame, padded
        run_frame(1, 7);                         // odd first byte: group bit
        run_frame(0, 1);                         // empty frame
        set_cur(8'h5F); pg_bound = 8'h5F;
        run_frame(600, 9);                       // wraps across ring end
        set_cur(8'h42); pg_bound = 8'h43;
        run_frame(300, 2);                       // needs 2, free 1: dropped
        run_frame(248, 5);                       // needs exactly 1: stored
        set_cur(8'h50); pg_bound = 8'h40;
        halt = 1'b1;
        run_frame(80, 6);                        // halted: discarded
        halt = 1'b0;
        pg_start = 8'h00;
        run_frame(80, 6);                        // zero start: discarded
        pg_start = 8'h40;

        for (int n = 0; n < 40; n++) begin
            pg_bound = 8'(8'h40 + ($urandom % 32));
            run_frame(int'($urandom % 700), int'($urandom % 256));
        end

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule